// File: doc/BRIEF.md
# Three-Tap Decision Feedback Equalizer Slicer

This block cleans up a stream of signed digital received samples, as produced by a converter-based serial receiver, and turns each sample into a hard bit decision. A channel smears each transmitted bit into the following bit periods. The block predicts that trailing interference from the three most recent decisions and subtracts it before slicing. Each prior decision counts as +1 when it was a 1 and as -1 when it was a 0, and is scaled by its own programmable signed coefficient. The current sample itself enters with unit weight, so the main cursor is never removed. Interference from the bit that follows is left in place, because that bit has not been decided yet.

A sample arrives with a valid strobe. The corrected value and its sign are formed in the same cycle. The decision is registered and appears with a one-cycle valid strobe on the next clock edge. That registered decision is at once the newest entry of the feedback history, so the loop through the first coefficient closes within one clock period, and back-to-back samples each see the decision made for the sample just before them. When no sample arrives, the history and the presented decision both hold.

Top module: `dfe_slicer`

## Requirements
- R1: For each valid sample, the corrected value is sample - C1*d1 - C2*d2 - C3*d3. Here dk is +1 when the decision k samples earlier was 1 and -1 when it was 0. C1 is coef_all[7:0], C2 is coef_all[15:8] and C3 is coef_all[23:16], all signed two's complement.
- R2: The decision is 1 when the corrected value is greater than or equal to zero, and 0 otherwise. A corrected value of exactly zero gives 1.
- R3: The corrected value is held in 11 signed bits and never wraps. This includes the extremes -512 (every term at -128) and +511.
- R4: dec_vld is high in exactly the cycle after a cycle with smp_vld high. dec_bit carries that sample's decision while dec_vld is high.
- R5: In a cycle without smp_vld, the decision history does not move and dec_bit keeps its value. Data on smp_data in such a cycle has no effect on later decisions.
- R6: Synchronous reset (rst_n low at a clock edge) clears dec_vld, sets dec_bit to 0 and fills the whole history with 0 decisions (-1).
- R7: With back-to-back valid samples, each decision uses the decision of the immediately preceding sample as d1, with no bubble.
- R8: Coefficients are applied in the cycle the sample is presented. A coefficient change made while idle takes effect on the next valid sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one sample per cycle at most |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | Sample valid strobe |
| smp_data | input | 8 | Signed received sample |
| coef_all | input | 24 | Three signed 8-bit post-cursor coefficients, C1 in the low byte |
| dec_vld | output | 1 | Decision valid, one cycle after smp_vld |
| dec_bit | output | 1 | Most recent hard decision |

## Verification
The hardest corner to reach from the ports is the summed extreme of the corrected value, where all three feedback terms and the sample push the same way at full scale. The stimulus reaches it by first steering the history into a known all-ones or all-zeros state, using large samples with zero coefficients. It then loads coefficients of -128 or +127 and sends a full-scale sample. The exact zero tie is reached the same way, by priming a known history and choosing a sample that cancels the coefficient sum to the last count.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
  parameter int DEF_SMP_W = 8;
  parameter int DEF_TAPS  = 3;

  // width of a sum of (taps + 1) signed values of smp_w bits, plus one guard bit
  function automatic int acc_width(input int smp_w, input int taps);
    return smp_w + $clog2(taps + 1) + 1;
  endfunction
endpackage

// File: rtl/dfe_history.sv
module dfe_history #(
  parameter int NTAPS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             new_bit,
  output logic [NTAPS-1:0] hist
);
  // hist[0] is the newest decision, hist[NTAPS-1] the oldest
  for (genvar k = 0; k < NTAPS; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)        hist[0] <= 1'b0;
        else if (shift_en) hist[0] <= new_bit;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n)        hist[k] <= 1'b0;
        else if (shift_en) hist[k] <= hist[k-1];
      end
    end
  end

  // R5
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist));

  // R7
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (hist[0] == $past(new_bit)));
endmodule

// File: rtl/dfe_combiner.sv
module dfe_combiner #(
  parameter int SMP_W = 8,
  parameter int NTAPS = 3,
  parameter int ACC_W = 11
) (
  input  logic signed [SMP_W-1:0]       sample,
  input  logic        [NTAPS*SMP_W-1:0] coef_all,
  input  logic        [NTAPS-1:0]       hist,
  output logic signed [ACC_W-1:0]       acc
);
  function automatic logic signed [ACC_W-1:0] widen(input logic [SMP_W-1:0] v);
    return {{(ACC_W-SMP_W){v[SMP_W-1]}}, v};
  endfunction

  // coefficient times a decision mapped to +1 / -1
  function automatic logic signed [ACC_W-1:0] fb_term(input logic [SMP_W-1:0] coef,
                                                      input logic dbit);
    logic signed [ACC_W-1:0] w;
    w = widen(coef);
    return dbit ? w : -w;
  endfunction

  logic signed [ACC_W-1:0] term [NTAPS];

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    assign term[k] = fb_term(coef_all[k*SMP_W +: SMP_W], hist[k]);
  end

  always_comb begin
    acc = widen(sample);
    for (int k = 0; k < NTAPS; k++) acc = acc - term[k];
  end
endmodule

// File: rtl/dfe_decision.sv
module dfe_decision #(
  parameter int ACC_W = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld,
  input  logic signed [ACC_W-1:0] acc,
  output logic                    slice_bit,
  output logic                    dec_vld
);
  function automatic logic slice(input logic signed [ACC_W-1:0] v);
    return ~v[ACC_W-1];
  endfunction

  assign slice_bit = slice(acc);

  always_ff @(posedge clk) begin
    if (!rst_n) dec_vld <= 1'b0;
    else        dec_vld <= smp_vld;
  end

  // R4
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> dec_vld);

  // R4
  vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> !dec_vld);
endmodule

// File: rtl/dfe_slicer.sv
module dfe_slicer #(
  parameter int SMP_W = dfe_pkg::DEF_SMP_W,
  parameter int NTAPS = dfe_pkg::DEF_TAPS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_vld,
  input  logic [SMP_W-1:0]       smp_data,
  input  logic [NTAPS*SMP_W-1:0] coef_all,
  output logic                   dec_vld,
  output logic                   dec_bit
);
  localparam int ACC_W = dfe_pkg::acc_width(SMP_W, NTAPS);

  logic [NTAPS-1:0]        hist;
  logic signed [ACC_W-1:0] corr;
  logic                    slice_bit;
  logic                    take_sample;

  assign take_sample = smp_vld;

  dfe_combiner #(.SMP_W(SMP_W), .NTAPS(NTAPS), .ACC_W(ACC_W)) u_comb (
    .sample   (smp_data),
    .coef_all (coef_all),
    .hist     (hist),
    .acc      (corr)
  );

  dfe_decision #(.ACC_W(ACC_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (take_sample),
    .acc       (corr),
    .slice_bit (slice_bit),
    .dec_vld   (dec_vld)
  );

  dfe_history #(.NTAPS(NTAPS)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (take_sample),
    .new_bit  (slice_bit),
    .hist     (hist)
  );

  // newest history entry is the presented decision
  assign dec_bit = hist[0];

  // R2
  slice_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_sample |=> (dec_bit == !$past(corr[ACC_W-1])));

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!dec_vld && hist == '0));
endmodule

// File: tb/tb_dfe_slicer.sv
module tb_dfe_slicer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_vld;
  logic [7:0]  smp_data;
  logic [23:0] coef_all;
  logic        dec_vld;
  logic        dec_bit;

  int checks = 0;
  int errors = 0;
  int mc[3];
  bit mh[3];
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  dfe_slicer dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .coef_all(coef_all), .dec_vld(dec_vld), .dec_bit(dec_bit)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_coef(input int a, input int b, input int c);
    mc[0] = a; mc[1] = b; mc[2] = c;
    coef_all = {8'(c), 8'(b), 8'(a)};
  endtask

  function automatic int model_corr(input int s);
    int v = s;
    for (int k = 0; k < 3; k++) v -= mc[k] * (mh[k] ? 1 : -1);
    return v;
  endfunction

  function automatic int next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'($signed(lfsr[7:0]));
  endfunction

  // entered and left at a falling edge
  task automatic send(input int s, input string req);
    int  c;
    bit  b;
    c = model_corr(s);
    b = (c >= 0);
    mh[2] = mh[1]; mh[1] = mh[0]; mh[0] = b;
    smp_data = 8'(s);
    smp_vld  = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    chk({req, " dec_vld"}, int'(dec_vld), 1);
    chk({req, " dec_bit"}, int'(dec_bit), int'(b));
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      smp_vld  = 1'b0;
      smp_data = 8'(next_rand());
      @(negedge clk);
      chk({req, " idle dec_vld"}, int'(dec_vld), 0);
      chk({req, " idle dec_bit"}, int'(dec_bit), int'(mh[0]));
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; smp_vld = 1'b1; smp_data = 8'd55;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; smp_vld = 1'b0;
    mh[0] = 0; mh[1] = 0; mh[2] = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R6 dec_vld after reset", int'(dec_vld), 0);
    chk("R6 dec_bit after reset", int'(dec_bit), 0);
    // history of -1 terms: 0 - 10*(-1) = +10 -> 1 ; then C3 view
    set_coef(10, 0, 0);
    send(-9, "R6 history -1 via C1");
    set_coef(0, 0, 20);
    send(-19, "R6 history -1 via C3");
  endtask

  task automatic t_linear();
    set_coef(12, -7, 3);
    send(40, "R1 a"); send(-5, "R1 b"); send(9, "R1 c");
    send(-30, "R1 d"); send(2, "R1 e"); send(-1, "R1 f");
  endtask

  task automatic t_tie();
    // prime history to all 1
    set_coef(0, 0, 0);
    send(5, "R2 prime"); send(5, "R2 prime"); send(5, "R2 prime");
    set_coef(10, 20, 30);
    send(60, "R2 zero gives 1");       // 60-60 = 0
    set_coef(0, 0, 0);
    send(5, "R2 prime"); send(5, "R2 prime"); send(5, "R2 prime");
    set_coef(10, 20, 30);
    send(59, "R2 minus one gives 0");  // 59-60 = -1
  endtask

  task automatic t_extreme();
    set_coef(0, 0, 0);
    send(-3, "R3 prime"); send(-3, "R3 prime"); send(-3, "R3 prime");
    set_coef(-128, -128, -128);
    send(-128, "R3 min -512");         // -128 - 3*128 = -512 -> 0
    set_coef(0, 0, 0);
    send(3, "R3 prime"); send(3, "R3 prime"); send(3, "R3 prime");
    set_coef(-128, -128, -128);
    send(127, "R3 max 511");           // 127 + 384 = 511 -> 1
    set_coef(0, 0, 0);
    send(3, "R3 prime"); send(3, "R3 prime"); send(3, "R3 prime");
    set_coef(127, 127, 127);
    send(-128, "R3 low -509");
  endtask

  task automatic t_back_to_back();
    set_coef(100, 0, 0);
    for (int i = 0; i < 8; i++) send(50, "R7 toggle by d1");
  endtask

  task automatic t_idle_gaps();
    set_coef(25, -15, 40);
    send(10, "R5 before gap"); send(-20, "R5 before gap");
    idle(4, "R5");
    set_coef(-30, 60, -10);
    idle(2, "R8");
    send(15, "R8 new coef after idle");
    send(-45, "R5 after gap");
    idle(1, "R4");
    send(70, "R4 single");
  endtask

  task automatic t_random();
    for (int i = 0; i < 150; i++) begin
      if (i % 25 == 0) set_coef(next_rand(), next_rand(), next_rand());
      if (i % 7 == 3) idle(1, "R5 random");
      send(next_rand(), "R1 random");
    end
  endtask

  task automatic t_reset_midrun();
    set_coef(0, 0, 0);
    send(9, "R6 pre"); send(9, "R6 pre");
    do_reset();
    chk("R6 dec_vld mid reset", int'(dec_vld), 0);
    set_coef(0, 50, 0);
    send(-49, "R6 cleared history");   // -49 + 50 = 1 -> 1
  endtask

  initial begin
    rst_n = 1'b0; smp_vld = 1'b0; smp_data = '0; coef_all = '0;
    @(negedge clk);
    t_reset();
    t_linear();
    t_tie();
    t_extreme();
    t_back_to_back();
    t_idle_gaps();
    t_random();
    t_reset_midrun();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule